// File: doc/BRIEF.md
# Auto-Precharge Bank Timing Tracker

This block follows one bank of a double-data-rate SDRAM through its open, write and precharge phases, watching the decoded command stream that a memory controller sends to the device. Each cycle it sees one command code, a bank address and the level of address bit 10. Commands addressed to other banks pass it by. It raises `bank_ready` whenever a new command to its bank may be issued, and it pulses `illegal_cmd` when a command reaches its bank while the bank is busy.

A write issued with address bit 10 high carries an implicit precharge. The tracker first counts out the data burst. It then counts the write-recovery interval and then the precharge interval. During all three phases it blocks the bank. It returns to idle only when the precharge time has run out, so the next activate is legal from that cycle. A write with bit 10 low returns the bank to the open-row state after the burst. An explicit precharge command from the open state starts the precharge countdown on its own. Burst length, write recovery and precharge time are parameters, counted in clock cycles.

The states are IDLE (no row open), ACTIVE (row open), WR_BURST (data beats), WR_RECOVERY (write recovery) and PRECHARGING (precharge time). The transitions are:

- IDLE→ACTIVE on activate.
- ACTIVE→WR_BURST on any write.
- ACTIVE→PRECHARGING on precharge.
- WR_BURST→ACTIVE when the burst ends without auto-precharge.
- WR_BURST→WR_RECOVERY when the burst ends with auto-precharge.
- WR_RECOVERY→PRECHARGING when recovery ends.
- PRECHARGING→IDLE when the precharge time ends.

Top module: `ap_bank_tracker`

## Requirements
- R1: When `rst_n` is low at a clock edge, the bank enters IDLE. After that edge, `bank_state` = 0, `bank_ready` = 1 and `illegal_cmd` = 0. The state codes are IDLE=0, ACTIVE=1, WR_BURST=2, WR_RECOVERY=3 and PRECHARGING=4.
- R2: An activate (`cmd` = 1) to this bank in IDLE moves the bank to ACTIVE at the next edge.
- R3: A write (`cmd` = 3) to this bank in ACTIVE with `cmd_a10` = 1 gives the following sequence after the command edge:
  - BURST_LEN cycles of WR_BURST,
  - then T_WR cycles of WR_RECOVERY,
  - then T_RP cycles of PRECHARGING,
  - then IDLE.
- R4: A write to this bank in ACTIVE with `cmd_a10` = 0 gives BURST_LEN cycles of WR_BURST and then returns the bank to ACTIVE.
- R5: A precharge (`cmd` = 4) to this bank in ACTIVE gives T_RP cycles of PRECHARGING and then IDLE.
- R6: Any command other than NOP addressed to this bank while it is in WR_BURST, WR_RECOVERY or PRECHARGING has two effects:
  - `illegal_cmd` is high for the cycle after that edge;
  - the state sequence and its timing are unchanged.
- R7: A command whose `cmd_bank` differs from BANK_ID changes neither the state nor `illegal_cmd`.
- R8: `bank_ready` is high exactly while the bank is in IDLE or ACTIVE.
- R9: The following commands leave the state unchanged and do not raise `illegal_cmd`:
  - read (`cmd` = 2) in ACTIVE;
  - activate in ACTIVE;
  - read, write or precharge in IDLE;
  - NOP (`cmd` = 0) and codes 5 to 7 in any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd | input | 3 | Decoded command: 0 NOP, 1 activate, 2 read, 3 write, 4 precharge |
| cmd_bank | input | BANK_W | Bank address of the command |
| cmd_a10 | input | 1 | Address bit 10; high on a write selects auto-precharge |
| bank_ready | output | 1 | A new command to this bank is allowed |
| illegal_cmd | output | 1 | One-cycle flag for a command that reached this bank while busy |
| bank_state | output | 3 | Current state code |

## Verification
The hardest case to reach from the ports is a command that arrives at one exact cycle inside the write, recovery and precharge chain. The boundary cycles matter most: the last beat of the burst, the hand-off from recovery to precharge, and the final precharge cycle just before IDLE. For each of these the flag must fire and the chain must not move. The bench reaches every such cycle by opening the bank, issuing a write with auto-precharge, and then waiting a swept number of cycles before it injects each of the four real commands. It walks the whole chain on every run and compares each cycle with a state computed from the parameters.

// File: rtl/ap_pkg.sv
package ap_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE        = 3'd0,
        ST_ACTIVE      = 3'd1,
        ST_WR_BURST    = 3'd2,
        ST_WR_RECOVERY = 3'd3,
        ST_PRECHARGING = 3'd4
    } bank_st_e;

    typedef struct packed {
        logic act;
        logic rd;
        logic wr;
        logic pre;
        logic any;
    } hit_t;

endpackage

// File: rtl/ap_cmd_decode.sv
module ap_cmd_decode
    import ap_pkg::*;
#(
    parameter int BANK_W  = 2,
    parameter int BANK_ID = 0
) (
    input  logic [2:0]        cmd,
    input  logic [BANK_W-1:0] cmd_bank,
    output hit_t              hit
);
    localparam logic [BANK_W-1:0] MY_BANK = BANK_W'(BANK_ID);

    logic mine;

    always_comb begin
        mine    = (cmd_bank == MY_BANK);
        hit.act = mine && (cmd == CMD_ACT);
        hit.rd  = mine && (cmd == CMD_RD);
        hit.wr  = mine && (cmd == CMD_WR);
        hit.pre = mine && (cmd == CMD_PRE);
        hit.any = hit.act || hit.rd || hit.wr || hit.pre;
    end
endmodule

// File: rtl/ap_down_counter.sv
module ap_down_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             at_zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign at_zero = (cnt_q == '0);

    // R3: the counter only moves down, never wraps
    p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && $past(rst_n) && !$past(load) && $past(cnt_q) == '0) |-> cnt_q == '0);
endmodule

// File: rtl/ap_bank_tracker.sv
module ap_bank_tracker
    import ap_pkg::*;
#(
    parameter int BANK_W    = 2,
    parameter int BANK_ID   = 0,
    parameter int BURST_LEN = 4,
    parameter int T_WR      = 2,
    parameter int T_RP      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cmd,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic              cmd_a10,
    output logic              bank_ready,
    output logic              illegal_cmd,
    output logic [2:0]        bank_state
);
    localparam int MAX_T0 = (BURST_LEN > T_WR) ? BURST_LEN : T_WR;
    localparam int MAX_T  = (MAX_T0 > T_RP) ? MAX_T0 : T_RP;
    localparam int CNT_W  = $clog2(MAX_T + 1);
    localparam logic [CNT_W-1:0] LD_BURST = CNT_W'(BURST_LEN - 1);
    localparam logic [CNT_W-1:0] LD_WR    = CNT_W'(T_WR - 1);
    localparam logic [CNT_W-1:0] LD_RP    = CNT_W'(T_RP - 1);

    initial begin
        assert (BURST_LEN >= 1 && T_WR >= 1 && T_RP >= 1)
            else $error("timing parameters must be at least one cycle");
    end

    hit_t             hit;
    bank_st_e         st_q, st_d;
    logic             ap_q;
    logic             ld;
    logic [CNT_W-1:0] ld_val;
    logic             cnt_zero;
    logic             busy;

    ap_cmd_decode #(.BANK_W(BANK_W), .BANK_ID(BANK_ID)) u_decode (
        .cmd      (cmd),
        .cmd_bank (cmd_bank),
        .hit      (hit)
    );

    ap_down_counter #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (ld_val),
        .at_zero  (cnt_zero)
    );

    // next state and timer loads
    always_comb begin
        st_d   = st_q;
        ld     = 1'b0;
        ld_val = '0;
        unique case (st_q)
            ST_IDLE: begin
                if (hit.act) st_d = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (hit.wr) begin
                    st_d   = ST_WR_BURST;
                    ld     = 1'b1;
                    ld_val = LD_BURST;
                end else if (hit.pre) begin
                    st_d   = ST_PRECHARGING;
                    ld     = 1'b1;
                    ld_val = LD_RP;
                end
            end
            ST_WR_BURST: begin
                if (cnt_zero) begin
                    if (ap_q) begin
                        st_d   = ST_WR_RECOVERY;
                        ld     = 1'b1;
                        ld_val = LD_WR;
                    end else begin
                        st_d = ST_ACTIVE;
                    end
                end
            end
            ST_WR_RECOVERY: begin
                if (cnt_zero) begin
                    st_d   = ST_PRECHARGING;
                    ld     = 1'b1;
                    ld_val = LD_RP;
                end
            end
            ST_PRECHARGING: begin
                if (cnt_zero) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
            ap_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_ACTIVE && hit.wr)
                ap_q <= cmd_a10;
        end
    end

    // outputs
    always_comb begin
        busy       = (st_q == ST_WR_BURST) || (st_q == ST_WR_RECOVERY) ||
                     (st_q == ST_PRECHARGING);
        bank_ready = !busy;
        bank_state = st_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            illegal_cmd <= 1'b0;
        else
            illegal_cmd <= busy && hit.any;
    end

    // R6: a flag only follows a cycle in which the bank was not ready
    p_flag_when_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal_cmd && $past(rst_n)) |-> !$past(bank_ready));

    // R3: recovery is entered only from an auto-precharge burst
    p_recovery_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WR_RECOVERY && $past(rst_n) && $past(st_q) != ST_WR_RECOVERY)
        |-> ($past(st_q) == ST_WR_BURST && $past(ap_q)));

    // R3: once recovery or precharge has begun the row cannot reopen directly
    p_no_reopen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WR_RECOVERY || st_q == ST_PRECHARGING) |=> st_q != ST_ACTIVE);

    // R4: a plain write burst returns to the open row
    p_plain_return_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WR_BURST && cnt_zero && !ap_q) |=> st_q == ST_ACTIVE);

    // R5: precharge time expiry leads to IDLE
    p_pre_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PRECHARGING && cnt_zero) |=> st_q == ST_IDLE);

    // R7: an open bank stays open when no command hits it
    p_other_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ACTIVE && !hit.any) |=> (st_q == ST_ACTIVE && !illegal_cmd));
endmodule

// File: tb/test_ap_bank_tracker.sv
module test_ap_bank_tracker;
    localparam int BW   = 2;
    localparam int BID  = 2;
    localparam int BL   = 4;
    localparam int TWR  = 2;
    localparam int TRP  = 3;
    localparam int TOT  = BL + TWR + TRP;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    cmd = 3'd0;
    logic [BW-1:0] cmd_bank = '0;
    logic          cmd_a10 = 1'b0;
    logic          bank_ready, illegal_cmd;
    logic [2:0]    bank_state;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    ap_bank_tracker #(.BANK_W(BW), .BANK_ID(BID), .BURST_LEN(BL),
                      .T_WR(TWR), .T_RP(TRP)) i_ap_bank_tracker (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .cmd_bank(cmd_bank),
        .cmd_a10(cmd_a10), .bank_ready(bank_ready),
        .illegal_cmd(illegal_cmd), .bank_state(bank_state)
    );

    // state expected i cycles after an auto-precharge write edge (i >= 1)
    function automatic int exp_ap(input int i);
        if (i <= BL) return 2;
        if (i <= BL + TWR) return 3;
        if (i <= TOT) return 4;
        return 0;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_state(input string req, input int exp);
        chk(req, int'(bank_state), exp);
        chk({req, " ready"}, int'(bank_ready), (exp <= 1) ? 1 : 0);
    endtask

    // drive one command for one clock edge, return at the following negedge
    task automatic tick(input int c, input int b, input logic a);
        cmd      = 3'(c);
        cmd_bank = BW'(b);
        cmd_a10  = a;
        @(negedge clk);
        cmd      = 3'd0;
        cmd_bank = '0;
        cmd_a10  = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(0, 0, 1'b0);
        tick(0, 0, 1'b0);
        rst_n = 1'b1;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        chk_state("R1 reset state", 0);
        chk("R1 reset flag", int'(illegal_cmd), 0);

        // R9: commands in IDLE other than activate are ignored
        for (int c = 2; c <= 7; c++) begin
            tick(c, BID, 1'b1);
            chk_state("R9 idle ignores", 0);
            chk("R9 idle no flag", int'(illegal_cmd), 0);
        end
        // R7: activate to other banks
        for (int b = 0; b < 4; b++) begin
            if (b != BID) begin
                tick(1, b, 1'b0);
                chk_state("R7 other bank act", 0);
            end
        end
        tick(1, BID, 1'b0);
        chk_state("R2 activate", 1);
        tick(1, BID, 1'b0);
        chk_state("R9 act in active", 1);
        tick(2, BID, 1'b1);
        chk_state("R9 read in active", 1);
        chk("R9 read no flag", int'(illegal_cmd), 0);
        for (int b = 0; b < 4; b++) begin
            if (b != BID) begin
                tick(3, b, 1'b1);
                chk_state("R7 other bank write", 1);
                tick(4, b, 1'b0);
                chk_state("R7 other bank pre", 1);
            end
        end

        // R4: plain write
        tick(3, BID, 1'b0);
        for (int i = 1; i <= BL + 2; i++) begin
            chk_state("R4 plain write", (i <= BL) ? 2 : 1);
            tick(0, 0, 1'b0);
        end

        // R5: explicit precharge
        tick(4, BID, 1'b0);
        for (int i = 1; i <= TRP + 2; i++) begin
            chk_state("R5 precharge", (i <= TRP) ? 4 : 0);
            tick(0, 0, 1'b0);
        end

        // R3/R8: full auto-precharge chain, other banks poked meanwhile (R7)
        tick(1, BID, 1'b0);
        tick(3, BID, 1'b1);
        for (int i = 1; i <= TOT + 2; i++) begin
            chk_state("R3 chain", exp_ap(i));
            chk("R7 flag quiet", int'(illegal_cmd), 0);
            tick((i % 4) + 1, (BID + 1 + (i % 3)) % 4, 1'b1);
        end

        // R6: sweep of injection offset and command type
        for (int d = 1; d <= TOT; d++) begin
            for (int c = 1; c <= 4; c++) begin
                do_reset();
                tick(1, BID, 1'b0);
                tick(3, BID, 1'b1);
                for (int k = 1; k < d; k++) tick(0, 0, 1'b0);
                tick(c, BID, 1'b1);
                chk("R6 flag raised", int'(illegal_cmd), 1);
                chk_state("R6 chain unchanged", exp_ap(d + 1));
                for (int i = d + 2; i <= TOT + 1; i++) begin
                    tick(0, 0, 1'b0);
                    if (i == d + 2) chk("R6 flag one cycle", int'(illegal_cmd), 0);
                    chk_state("R6 chain continues", exp_ap(i));
                end
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule